// File: doc/BRIEF.md
# Dithering Grayscale Generator

This block sits in an LCD video path and turns 3-bit intensity values into one on/off bit per colour channel. It has three independent slices, for red, green and blue. Each slice switches its output bit in a programmed pattern across neighbouring columns, neighbouring lines and successive frames. The eye averages that pattern into one of 8 levels, from fully dark to fully lit. A monochrome panel can therefore show gray shades, and an 8-colour panel can show extra colours.

Each slice holds a 512-entry, 1-bit dither table and a 3-bit axis-size code for each intensity value. The size code picks a 3-cycle or a 4-cycle phase counter separately for the frame, line and column axes. A shared phase generator keeps both counter lengths for every axis. Its counters advance on pixel, line and frame markers from the timing logic upstream. Software loads the tables one bit at a time and the size codes one value at a time through two simple write ports. A low enable bypasses the dithering, and each channel then shows the top bit of its intensity.

Top module: `pixel_dither_gen`

## Requirements
- R1: The blue slice takes `color_in[7:5]`, the green slice `color_in[15:13]` and the red slice `color_in[23:21]`. `pix_out[2]` is red, `pix_out[1]` is green and `pix_out[0]` is blue.
- R2: With `en` high, each channel's output bit is the table bit at address {value[2:0], frame phase[1:0], line phase[1:0], column phase[1:0]}. Each phase comes from the 3-cycle or the 4-cycle counter, as the size code of that value selects.
- R3: The column counters advance on each cycle with `pix_valid` high and clear to 0 on `line_start`, which wins over advancing. The 3-cycle counter wraps 2→0 and the 4-cycle counter wraps 3→0. A pixel uses the phase held before that cycle's update.
- R4: The line counters advance on `line_end` and clear to 0 on `frame_start`, with the same wrap rules as R3.
- R5: The frame counters advance on `frame_end`, wrap as in R3, and clear only on reset.
- R6: A write with `sel_we` stores `sel_mode` as the size code of value `sel_val` in channel `sel_ch` (0 blue, 1 green, 2 red, 3 none). Bit 2 is frame, bit 1 is line and bit 0 is column; a 1 selects the 4-cycle counter.
- R7: A write with `tbl_we` stores `tbl_bit` at `tbl_addr` in the table of channel `tbl_ch` (0 blue, 1 green, 2 red). The other tables are unchanged, and `tbl_ch` = 3 changes no table.
- R8: With `en` low, each channel outputs bit 2 of its own 3-bit value.
- R9: `pix_out` is registered. `pix_out_valid` is high exactly one cycle after a cycle with `pix_valid` high, together with that pixel's result.
- R10: Reset (synchronous, active high) clears `pix_out`, `pix_out_valid` and all phase counters, and sets every size code to 3-cycle on all axes. Reset does not clear the tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Dither enable; low gives MSB bypass |
| pix_valid | input | 1 | Pixel strobe for `color_in` |
| line_start | input | 1 | Clears the column counters |
| line_end | input | 1 | Advances the line counters |
| frame_start | input | 1 | Clears the line counters |
| frame_end | input | 1 | Advances the frame counters |
| color_in | input | 24 | Colour word, 8 bits per channel |
| tbl_we | input | 1 | Table bit write strobe |
| tbl_ch | input | 2 | Table channel select |
| tbl_addr | input | 9 | Table bit address |
| tbl_bit | input | 1 | Table bit to write |
| sel_we | input | 1 | Size code write strobe |
| sel_ch | input | 2 | Size code channel select |
| sel_val | input | 3 | Intensity value whose code is written |
| sel_mode | input | 3 | Size code {frame, line, column} |
| pix_out | output | 3 | Dithered pixel {red, green, blue} |
| pix_out_valid | output | 1 | Marks a valid `pix_out` |

## Verification
Every slice is loaded with a table whose bits are the parities of a different mask of the address. A wrong field order or a wrong counter phase therefore flips the expected bits. Long runs of pixels inside one line show whether the column counter wraps after 3 or after 4 cycles. Runs of lines inside a frame test the line counters, and runs of 13 frames test the frame counters across both lengths. Size codes cover all 8 axis combinations and are changed between runs, while values 0 and 7 hold solid tables for the off and full-on shades. Distinct per-channel values, bypass runs and single-bit writes (including a write to the unused channel code) show that each slice reads only its own bits and its own table.

// File: rtl/dith_pkg.sv
package dith_pkg;
  localparam int PH_W   = 2;
  localparam int VAL_W  = 3;
  localparam int NCH    = 3;
  localparam int CH_W   = 2;
  localparam int COMP_W = 8;

  typedef struct packed {
    logic [PH_W-1:0] f3;
    logic [PH_W-1:0] f4;
    logic [PH_W-1:0] v3;
    logic [PH_W-1:0] v4;
    logic [PH_W-1:0] h3;
    logic [PH_W-1:0] h4;
  } dith_phase_t;
endpackage

// File: rtl/dith_mod_ctr.sv
module dith_mod_ctr #(
  parameter int MOD = 3,
  parameter int W   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (inc)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/dith_phase_gen.sv
module dith_phase_gen
  import dith_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        pix_valid,
  input  logic        line_start,
  input  logic        line_end,
  input  logic        frame_start,
  input  logic        frame_end,
  output dith_phase_t phase
);
  dith_mod_ctr #(.MOD(3), .W(PH_W)) u_h3 (.clk, .rst, .clr(line_start),  .inc(pix_valid), .cnt(phase.h3));
  dith_mod_ctr #(.MOD(4), .W(PH_W)) u_h4 (.clk, .rst, .clr(line_start),  .inc(pix_valid), .cnt(phase.h4));
  dith_mod_ctr #(.MOD(3), .W(PH_W)) u_v3 (.clk, .rst, .clr(frame_start), .inc(line_end),  .cnt(phase.v3));
  dith_mod_ctr #(.MOD(4), .W(PH_W)) u_v4 (.clk, .rst, .clr(frame_start), .inc(line_end),  .cnt(phase.v4));
  dith_mod_ctr #(.MOD(3), .W(PH_W)) u_f3 (.clk, .rst, .clr(1'b0),        .inc(frame_end), .cnt(phase.f3));
  dith_mod_ctr #(.MOD(4), .W(PH_W)) u_f4 (.clk, .rst, .clr(1'b0),        .inc(frame_end), .cnt(phase.f4));
endmodule

// File: rtl/dith_slice.sv
module dith_slice
  import dith_pkg::*;
#(
  parameter int VW = VAL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [VW-1:0]          val,
  input  dith_phase_t            phase,
  input  logic                   tbl_we,
  input  logic [VW+3*PH_W-1:0]   tbl_addr,
  input  logic                   tbl_bit,
  input  logic                   sel_we,
  input  logic [VW-1:0]          sel_val,
  input  logic [2:0]             sel_mode,
  output logic                   q
);
  localparam int ADDR_W = VW + 3 * PH_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NVAL   = 1 << VW;

  logic            mem [DEPTH];
  logic [2:0]      mode_q [NVAL];
  logic [2:0]      mode;
  logic [PH_W-1:0] fs, vs, hs;
  logic [ADDR_W-1:0] rd_addr;

  // table storage: write-only port, no reset, inferable as RAM
  always_ff @(posedge clk) begin
    if (tbl_we) mem[tbl_addr] <= tbl_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NVAL; i++) mode_q[i] <= '0;
    end else if (sel_we) begin
      mode_q[sel_val] <= sel_mode;
    end
  end

  always_comb begin
    mode    = mode_q[val];
    fs      = mode[2] ? phase.f4 : phase.f3;
    vs      = mode[1] ? phase.v4 : phase.v3;
    hs      = mode[0] ? phase.h4 : phase.h3;
    rd_addr = {val, fs, vs, hs};
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= en ? mem[rd_addr] : val[VW-1];
  end
endmodule

// File: rtl/pixel_dither_gen.sv
module pixel_dither_gen
  import dith_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        pix_valid,
  input  logic        line_start,
  input  logic        line_end,
  input  logic        frame_start,
  input  logic        frame_end,
  input  logic [23:0] color_in,
  input  logic        tbl_we,
  input  logic [1:0]  tbl_ch,
  input  logic [8:0]  tbl_addr,
  input  logic        tbl_bit,
  input  logic        sel_we,
  input  logic [1:0]  sel_ch,
  input  logic [2:0]  sel_val,
  input  logic [2:0]  sel_mode,
  output logic [2:0]  pix_out,
  output logic        pix_out_valid
);
  localparam int COLOR_W = NCH * COMP_W;

  function automatic logic [COLOR_W-1:0] used_mask();
    logic [COLOR_W-1:0] m = '0;
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < VAL_W; b++)
        m[c*COMP_W + COMP_W - 1 - b] = 1'b1;
    return m;
  endfunction

  localparam logic [COLOR_W-1:0] USED = used_mask();

  dith_phase_t        phase;
  logic [COLOR_W-1:0] unused_color_bits;

  assign unused_color_bits = color_in & ~USED;

  dith_phase_gen u_phase (
    .clk, .rst, .pix_valid, .line_start, .line_end,
    .frame_start, .frame_end, .phase
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dith_slice #(.VW(VAL_W)) u_slice (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .val      (color_in[c*COMP_W + COMP_W - 1 -: VAL_W]),
      .phase    (phase),
      .tbl_we   (tbl_we && (tbl_ch == CH_W'(c))),
      .tbl_addr (tbl_addr),
      .tbl_bit  (tbl_bit),
      .sel_we   (sel_we && (sel_ch == CH_W'(c))),
      .sel_val  (sel_val),
      .sel_mode (sel_mode),
      .q        (pix_out[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pix_out_valid <= 1'b0;
    else     pix_out_valid <= pix_valid;
  end
endmodule

// File: rtl/dith_chk.sv
module dith_chk
  import dith_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic        pix_valid,
  input logic        line_start,
  input logic        frame_start,
  input logic        frame_end,
  input logic [23:0] color_in,
  input logic [2:0]  pix_out,
  input logic        pix_out_valid,
  input dith_phase_t phase
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (!rst && pix_valid) |=> pix_out_valid);
  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (!rst && !pix_valid) |=> !pix_out_valid);
  assert_bypass_msb_R8: assert property (@(posedge clk) disable iff (rst)
    (!rst && pix_valid && !en) |=>
      pix_out == {$past(color_in[23]), $past(color_in[15]), $past(color_in[7])});
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!pix_out_valid && pix_out == 3'b000));
  assert_col_range_R3: assert property (@(posedge clk) disable iff (rst)
    phase.h3 != 2'd3);
  assert_col_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (!rst && line_start) |=> (phase.h3 == 2'd0 && phase.h4 == 2'd0));
  assert_line_range_R4: assert property (@(posedge clk) disable iff (rst)
    phase.v3 != 2'd3);
  assert_line_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && frame_start) |=> (phase.v3 == 2'd0 && phase.v4 == 2'd0));
  assert_frame_range_R5: assert property (@(posedge clk) disable iff (rst)
    phase.f3 != 2'd3);
  assert_frame_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && !frame_end) |=> ($stable(phase.f3) && $stable(phase.f4)));
endmodule

bind pixel_dither_gen dith_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .pix_valid(pix_valid),
  .line_start(line_start), .frame_start(frame_start), .frame_end(frame_end),
  .color_in(color_in), .pix_out(pix_out), .pix_out_valid(pix_out_valid),
  .phase(phase)
);

// File: tb/pixel_dither_gen_tb.sv
`timescale 1ns/1ps
module pixel_dither_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1, pix_valid = 1'b0, line_start = 1'b0, line_end = 1'b0;
  logic frame_start = 1'b0, frame_end = 1'b0;
  logic [23:0] color_in = '0;
  logic tbl_we = 1'b0, tbl_bit = 1'b0, sel_we = 1'b0;
  logic [1:0] tbl_ch = '0, sel_ch = '0;
  logic [8:0] tbl_addr = '0;
  logic [2:0] sel_val = '0, sel_mode = '0;
  logic [2:0] pix_out;
  logic pix_out_valid;

  int n_vec = 0, n_bad = 0;
  int h = 0, v = 0, f = 0;
  logic tbl_ref [3][512];
  logic [2:0] mode_ref [3][8];
  logic [31:0] seed = 32'h1234_5678;
  bit done = 0;

  always #2.5 clk = ~clk;

  pixel_dither_gen u_dut (.*);

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [8:0] addr_of(int c, logic [2:0] val);
    logic [2:0] m = mode_ref[c][val];
    int fs = m[2] ? f % 4 : f % 3;
    int vs = m[1] ? v % 4 : v % 3;
    int hs = m[0] ? h % 4 : h % 3;
    return {val, 2'(fs), 2'(vs), 2'(hs)};
  endfunction

  function automatic logic [2:0] expect_pix(logic [23:0] col);
    logic [2:0] r;
    for (int c = 0; c < 3; c++) begin
      logic [2:0] val = col[c*8+7 -: 3];
      r[c] = en ? tbl_ref[c][addr_of(c, val)] : val[2];
    end
    return r;
  endfunction

  function automatic logic [23:0] next_color();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[23:0];
  endfunction

  task automatic write_bit(int c, int a, logic b);
    @(negedge clk);
    tbl_we = 1'b1; tbl_ch = 2'(c); tbl_addr = 9'(a); tbl_bit = b;
    @(negedge clk);
    tbl_we = 1'b0;
    if (c < 3) tbl_ref[c][a] = b;
  endtask

  task automatic write_mode(int c, int val, logic [2:0] m);
    @(negedge clk);
    sel_we = 1'b1; sel_ch = 2'(c); sel_val = 3'(val); sel_mode = m;
    @(negedge clk);
    sel_we = 1'b0;
    if (c < 3) mode_ref[c][val] = m;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: line_start = 1'b1;
      1: line_end = 1'b1;
      2: frame_start = 1'b1;
      default: frame_end = 1'b1;
    endcase
    @(negedge clk);
    line_start = 1'b0; line_end = 1'b0; frame_start = 1'b0; frame_end = 1'b0;
    case (which)
      0: h = 0;
      1: v++;
      2: v = 0;
      default: f++;
    endcase
  endtask

  task automatic send_pixel(string tag, logic [23:0] col);
    logic [2:0] exp;
    @(negedge clk);
    pix_valid = 1'b1; color_in = col;
    exp = expect_pix(col);
    @(negedge clk);
    pix_valid = 1'b0;
    check(tag, {pix_out_valid, pix_out}, {1'b1, exp});
    h++;
  endtask

  task automatic run_frame(string tag, int lines, int pixels);
    pulse(2);
    for (int l = 0; l < lines; l++) begin
      pulse(0);
      for (int p = 0; p < pixels; p++) send_pixel(tag, next_color());
      pulse(1);
    end
    pulse(3);
  endtask

  task automatic fill_tables();
    logic [8:0] mask [3];
    mask[0] = 9'h0B5; mask[1] = 9'h06B; mask[2] = 9'h157;
    for (int c = 0; c < 3; c++)
      for (int a = 0; a < 512; a++) begin
        logic [2:0] val = a[8:6];
        logic b = (val == 3'd0) ? 1'b0 : (val == 3'd7) ? 1'b1 : ^(9'(a) & mask[c]);
        write_bit(c, a, b);
      end
  endtask

  task automatic t_reset_R10();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {pix_out_valid, pix_out}, 4'b0000);
    rst = 1'b0;
    h = 0; v = 0; f = 0;
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 8; k++) mode_ref[c][k] = 3'b000;
  endtask

  task automatic t_column_R3();
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 8; k++) write_mode(c, k, 3'(k ^ c));
    pulse(2);
    pulse(0);
    for (int p = 0; p < 14; p++) send_pixel("R3 column phase", next_color());
    pulse(0);
    for (int p = 0; p < 7; p++) send_pixel("R3 column clear", next_color());
    pulse(1);
  endtask

  task automatic t_line_R4();
    run_frame("R4 line phase", 9, 5);
    run_frame("R4 line clear", 5, 4);
  endtask

  task automatic t_frame_R5();
    for (int k = 0; k < 13; k++) run_frame("R5 frame phase", 2, 3);
  endtask

  task automatic t_modes_R6();
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 8; k++) write_mode(c, k, 3'(7 - k + c));
    write_mode(3, 2, 3'b111);
    for (int k = 0; k < 6; k++) run_frame("R6 size codes", 5, 5);
  endtask

  task automatic t_channels_R1();
    pulse(0);
    send_pixel("R1 channel map", 24'hE0_00_00);
    send_pixel("R1 channel map", 24'h00_E0_00);
    send_pixel("R1 channel map", 24'h00_00_E0);
    send_pixel("R1 channel map", 24'h1F_1F_1F);
    send_pixel("R1 channel map", 24'h60_A0_C0);
    send_pixel("R1 channel map", 24'hC0_60_A0);
    pulse(1);
  endtask

  task automatic t_shades_R2();
    pulse(0);
    for (int p = 0; p < 12; p++) send_pixel("R2 off shade", 24'h1F_1F_1F);
    for (int p = 0; p < 12; p++) send_pixel("R2 on shade", 24'hFF_FF_FF);
    for (int p = 0; p < 12; p++) send_pixel("R2 mixed", 24'h40_80_A0);
    pulse(1);
  endtask

  task automatic t_write_R7();
    logic [23:0] col = 24'h60_A0_40;
    logic [8:0] a;
    pulse(0);
    a = addr_of(1, 3'd5);
    write_bit(1, a, ~tbl_ref[1][a]);
    send_pixel("R7 green write", col);
    a = addr_of(2, 3'd3);
    write_bit(3, a, ~tbl_ref[2][a]);
    write_bit(3, addr_of(0, 3'd2), ~tbl_ref[0][addr_of(0, 3'd2)]);
    send_pixel("R7 channel 3 ignored", col);
    pulse(1);
  endtask

  task automatic t_bypass_R8();
    @(negedge clk);
    en = 1'b0;
    pulse(0);
    for (int p = 0; p < 10; p++) send_pixel("R8 bypass", next_color());
    @(negedge clk);
    en = 1'b1;
    for (int p = 0; p < 4; p++) send_pixel("R8 enable restored", next_color());
    pulse(1);
  endtask

  task automatic t_valid_R9();
    send_pixel("R9 latency", next_color());
    @(negedge clk);
    check("R9 valid drops", {3'b000, pix_out_valid}, 4'b0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_R10();
    fill_tables();
    t_reset_R10();
    run_frame("R10 default codes", 4, 7);
    t_column_R3();
    t_line_R4();
    t_frame_R5();
    t_channels_R1();
    t_shades_R2();
    t_modes_R6();
    t_write_R7();
    t_bypass_R8();
    t_valid_R9();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule